// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 14-bit virtual address into a physical address by walking a sparse two-level translation tree held in memory. A request carries the virtual address plus two attributes: whether the access is a write and whether it comes from user mode. The walker forms the first entry address from a table-root register and the upper index field. It reads that entry over a single-outstanding memory port. If the entry is usable, it follows the pointer it holds to a leaf table and reads the leaf entry chosen by the middle index field.

The leaf entry is checked in a fixed priority order. The response reports either a physical address or one of three fault kinds. On a clean translation the walker writes the leaf entry back with the accessed flag set, and with the dirty flag set on writes. It skips that write when the flags already hold the needed values. Translation caching, fault handling and paging to disk are left to other blocks.

Top module: `page_walker_2l`

## Requirements
- R1: The first read of every walk targets root + 4 × VA[13:10], where the root is `ptbr` sampled when the request is accepted.
- R2: An entry's frame number sits at bits [17:8] (10 bits). A usable first-level entry makes the second read target (frame << 6) + 4 × VA[9:6], so a clean walk issues exactly two reads.
- R3: A first-level entry with bit 7 (valid) clear ends the walk with fault code 1 after exactly one read, whatever its other bits hold.
- R4: A leaf entry with bit 7 clear yields fault code 1.
- R5: A valid leaf yields fault code 2 when a write meets bit 1 (writable) clear, or a user access meets bit 2 (user) clear. This check takes priority over the present check.
- R6: A valid leaf that passes the permission check but has bit 0 (present) clear yields fault code 3.
- R7: A clean walk returns fault code 0 and a physical address of {leaf frame, VA[5:0]}. Any faulting walk returns address 0.
- R8: After a clean walk, the leaf word in memory has bit 5 (accessed) set, and also bit 6 (dirty) set when the access was a write. Exactly one write is issued if that changes the word, and none otherwise.
- R9: A faulting walk issues no memory write and leaves every entry unchanged.
- R10: The memory port holds request, address and write-enable stable until granted. At most one read is outstanding. A new walk is accepted only while `req_ready` is high.
- R11: After reset, `req_ready` is high while `rsp_valid` and `mem_req` are low. `rsp_valid` is a single-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | 16 | Byte address of the first-level table |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 14 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 protection, 3 not present |
| rsp_pa | output | 16 | Physical address, 0 on fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets the following corner cases:

- A root entry that is invalid but carries other set bits. A walker that fetched the leaf anyway would show a second read in the count.
- A write to a page that is both read-only and absent. A design with the wrong check order would report code 3 instead of 2.
- Repeated walks to the same page, first a read and then a write. These expose a missing dirty update, or a redundant write-back when both flags are already set.
- The last index in both levels at the top of the address space. This catches index arithmetic that overflows.
- A grant that stalls every fourth cycle. A walker that changes its address before the grant would fetch the wrong entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_P_BIT  = 0;
  localparam int PTE_W_BIT  = 1;
  localparam int PTE_U_BIT  = 2;
  localparam int PTE_A_BIT  = 5;
  localparam int PTE_D_BIT  = 6;
  localparam int PTE_V_BIT  = 7;
  localparam int PFN_LSB    = 8;
  localparam int ENT_LOG2   = 2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2,
    FLT_ABSENT  = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_LEAF_REQ, ST_LEAF_WAIT, ST_UPD_REQ, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int PA_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  ent_addr
);
  import ptw_pkg::*;
  always_comb ent_addr = tbl_base + (PA_W'(idx) << ENT_LOG2);
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check #(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0]  pte,
  input  logic              is_write,
  input  logic              is_user,
  output ptw_pkg::fault_e   fault,
  output logic              need_upd,
  output logic [PTE_W-1:0]  pte_upd
);
  import ptw_pkg::*;
  always_comb begin
    pte_upd = pte;
    pte_upd[PTE_A_BIT] = 1'b1;
    if (is_write) pte_upd[PTE_D_BIT] = 1'b1;
    need_upd = (pte_upd != pte);
    if (!pte[PTE_V_BIT])
      fault = FLT_INVALID;
    else if ((is_write && !pte[PTE_W_BIT]) || (is_user && !pte[PTE_U_BIT]))
      fault = FLT_PROT;
    else if (!pte[PTE_P_BIT])
      fault = FLT_ABSENT;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/page_walker_2l.sv
module page_walker_2l #(
  parameter int VA_W  = 14,
  parameter int OFF_W = 6,
  parameter int PA_W  = 16,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  ptbr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata
);
  import ptw_pkg::*;
  localparam int IDX_W = (VA_W - OFF_W) / 2;
  localparam int PFN_W = PA_W - OFF_W;

  logic rst_s_n;
  ptw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  walk_st_e         state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, usr_q;
  logic [PA_W-1:0]  base_q, leaf_addr_q;
  logic [PTE_W-1:0] ent_q;
  fault_e           fault_q, fault_d;
  logic             cap_req, cap_ent, cap_leaf, ld_fault;

  logic [PA_W-1:0]  dir_addr, leaf_addr, leaf_base;
  logic [PTE_W-1:0] chk_pte, pte_upd;
  fault_e           chk_fault;
  logic             need_upd;

  assign leaf_base = {ent_q[PFN_LSB +: PFN_W], {OFF_W{1'b0}}};

  ptw_addr_calc #(.PA_W(PA_W), .IDX_W(IDX_W)) u_dir_addr (
    .tbl_base(base_q), .idx(va_q[VA_W-1 -: IDX_W]), .ent_addr(dir_addr));
  ptw_addr_calc #(.PA_W(PA_W), .IDX_W(IDX_W)) u_leaf_addr (
    .tbl_base(leaf_base), .idx(va_q[OFF_W +: IDX_W]), .ent_addr(leaf_addr));

  assign chk_pte = (state_q == ST_LEAF_WAIT) ? mem_rdata : ent_q;
  ptw_leaf_check #(.PTE_W(PTE_W)) u_chk (
    .pte(chk_pte), .is_write(wr_q), .is_user(usr_q),
    .fault(chk_fault), .need_upd(need_upd), .pte_upd(pte_upd));

  always_comb begin
    state_d   = state_q;
    fault_d   = fault_q;
    cap_req   = 1'b0;
    cap_ent   = 1'b0;
    cap_leaf  = 1'b0;
    ld_fault  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dir_addr;
    mem_wdata = pte_upd;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        cap_req = 1'b1; ld_fault = 1'b1; fault_d = FLT_NONE; state_d = ST_DIR_REQ;
      end
      ST_DIR_REQ: begin
        mem_req = 1'b1;
        if (mem_gnt) state_d = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: if (mem_rvalid) begin
        cap_ent = 1'b1;
        if (!mem_rdata[PTE_V_BIT]) begin
          ld_fault = 1'b1; fault_d = FLT_INVALID; state_d = ST_DONE;
        end else state_d = ST_LEAF_REQ;
      end
      ST_LEAF_REQ: begin
        mem_req  = 1'b1;
        mem_addr = leaf_addr;
        if (mem_gnt) begin cap_leaf = 1'b1; state_d = ST_LEAF_WAIT; end
      end
      ST_LEAF_WAIT: if (mem_rvalid) begin
        cap_ent  = 1'b1;
        ld_fault = 1'b1;
        fault_d  = chk_fault;
        if (chk_fault == FLT_NONE && need_upd) state_d = ST_UPD_REQ;
        else                                    state_d = ST_DONE;
      end
      ST_UPD_REQ: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = leaf_addr_q;
        if (mem_gnt) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      base_q      <= '0;
      ent_q       <= '0;
      leaf_addr_q <= '0;
      fault_q     <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (cap_req) begin
        va_q <= req_va; wr_q <= req_write; usr_q <= req_user; base_q <= ptbr;
      end
      if (cap_ent)  ent_q       <= mem_rdata;
      if (cap_leaf) leaf_addr_q <= leaf_addr;
      if (ld_fault) fault_q     <= fault_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_fault = fault_q;
  assign rsp_pa    = (rsp_valid && fault_q == FLT_NONE)
                   ? {ent_q[PFN_LSB +: PFN_W], va_q[OFF_W-1:0]} : '0;

  assert_hold_until_grant_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_idle_no_access_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_ready |-> !mem_req);
  assert_rvalid_only_waiting_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_rvalid |-> (state_q == ST_DIR_WAIT || state_q == ST_LEAF_WAIT));
  assert_no_write_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req && mem_we |-> fault_q == FLT_NONE);
  assert_rsp_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/page_walker_2l_tb_top.sv
module page_walker_2l_tb_top;
  localparam logic [7:0] FP = 8'h01, FW = 8'h02, FU = 8'h04, FA = 8'h20, FD = 8'h40, FV = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] ptbr;
  logic req_valid, req_ready, req_write, req_user, rsp_valid;
  logic [13:0] req_va;
  logic [1:0]  rsp_fault;
  logic [15:0] rsp_pa, mem_addr;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_wdata, mem_rdata;

  page_walker_2l dut_i (.clk(clk), .rst_n(rst_n), .ptbr(ptbr), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  logic [31:0] mem [logic [15:0]];
  logic [1:0]  stall_cnt = 2'd0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [15:0] first_addr = '0;
  int nchk = 0, nfail = 0;

  function automatic logic [31:0] rd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] mk(logic [9:0] pfn, logic [7:0] fl);
    return {14'b0, pfn, fl};
  endfunction

  assign mem_gnt = mem_req && (stall_cnt != 2'd3);

  always @(posedge clk) begin
    stall_cnt  <= stall_cnt + 2'd1;
    mem_rvalid <= 1'b0;
    if (req_valid && req_ready) begin rd_cnt <= 0; wr_cnt <= 0; end
    else if (mem_req && mem_gnt) begin
      if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(mem_addr);
        if (rd_cnt == 0) first_addr <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  typedef struct {
    string rq; logic [1:0] fault; logic [15:0] pa; int reads; int writes;
    logic [15:0] dir_a; logic [15:0] leaf_a; logic [31:0] leaf_w; bit has_leaf;
  } exp_t;
  exp_t q[$];

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic walk(logic [3:0] di, logic [3:0] ti, logic [5:0] off, bit wr, bit usr);
    exp_t e;
    logic [31:0] de, le, nw;
    e.dir_a = ptbr + {10'b0, di, 2'b00};
    de = rd(e.dir_a);
    e.has_leaf = 0; e.pa = '0; e.writes = 0; e.leaf_a = '0; e.leaf_w = '0;
    if (!de[7]) begin
      e.rq = "R3"; e.fault = 2'd1; e.reads = 1;
    end else begin
      e.reads = 2; e.has_leaf = 1;
      e.leaf_a = {de[17:8], 6'b0} + {10'b0, ti, 2'b00};
      le = rd(e.leaf_a); e.leaf_w = le;
      if (!le[7]) begin e.rq = "R4"; e.fault = 2'd1; end
      else if ((wr && !le[1]) || (usr && !le[2])) begin e.rq = "R5"; e.fault = 2'd2; end
      else if (!le[0]) begin e.rq = "R6"; e.fault = 2'd3; end
      else begin
        e.rq = "R7"; e.fault = 2'd0; e.pa = {le[17:8], off};
        nw = le | 32'h20 | (wr ? 32'h40 : 32'h0);
        e.writes = (nw != le) ? 1 : 0; e.leaf_w = nw;
      end
    end
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va = {di, ti, off}; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.rq, "fault", 32'(rsp_fault), 32'(e.fault));
      chk("R7", "pa", 32'(rsp_pa), 32'(e.pa));
      chk("R1", "first read addr", 32'(first_addr), 32'(e.dir_a));
      chk(e.reads == 1 ? "R3" : "R2", "read count", rd_cnt, e.reads);
      chk(e.fault == 2'd0 ? "R8" : "R9", "write count", wr_cnt, e.writes);
      if (e.has_leaf) chk(e.fault == 2'd0 ? "R8" : "R9", "leaf word", rd(e.leaf_a), e.leaf_w);
      @(negedge clk);
      chk("R11", "pulse", 32'(rsp_valid), 32'd0);
    end
  end

  initial begin
    req_valid = 0; req_va = '0; req_write = 0; req_user = 0; ptbr = 16'h0400;
    mem[16'h0400] = mk(10'h020, FV);
    mem[16'h0404] = 32'h0;
    mem[16'h0408] = mk(10'h030, FP | FW | FU);
    mem[16'h043C] = mk(10'h3FF, FV);
    mem[16'h0800] = mk(10'h155, FV | FP | FW | FU);
    mem[16'h0804] = mk(10'h100, FP | FW | FU);
    mem[16'h0808] = mk(10'h101, FV | FW | FU);
    mem[16'h080C] = mk(10'h102, FV | FP | FU);
    mem[16'h0810] = mk(10'h103, FV | FP | FW);
    mem[16'h0814] = mk(10'h104, FV | FU);
    mem[16'h0818] = mk(10'h3FF, FV | FP | FW | FU | FA | FD);
    mem[16'hFFFC] = mk(10'h001, FV | FP | FW | FU);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "reset ready", 32'(req_ready), 32'd1);
    chk("R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11", "reset mem_req", 32'(mem_req), 32'd0);
    walk(4'd0, 4'd0, 6'h2A, 0, 1);  // R7 R8 accessed set
    walk(4'd0, 4'd0, 6'h01, 0, 1);  // R8 no redundant write
    walk(4'd0, 4'd0, 6'h3F, 1, 1);  // R8 dirty set
    walk(4'd1, 4'd5, 6'h00, 0, 0);  // R3
    walk(4'd2, 4'd0, 6'h00, 1, 1);  // R3 invalid with other bits set
    walk(4'd0, 4'd1, 6'h10, 0, 0);  // R4
    walk(4'd0, 4'd2, 6'h00, 0, 1);  // R6
    walk(4'd0, 4'd3, 6'h05, 1, 1);  // R5 read-only
    walk(4'd0, 4'd3, 6'h05, 0, 1);  // R7
    walk(4'd0, 4'd4, 6'h00, 0, 1);  // R5 supervisor page
    walk(4'd0, 4'd4, 6'h22, 1, 0);  // R7 R8
    walk(4'd0, 4'd5, 6'h00, 1, 1);  // R5 beats absent
    walk(4'd0, 4'd5, 6'h00, 0, 1);  // R6
    walk(4'd0, 4'd6, 6'h11, 1, 1);  // R8 flags already set
    walk(4'd15, 4'd15, 6'h3F, 0, 1); // R1 R2 top indices
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: walk did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule